// File: doc/BRIEF.md
# Contiguous Concatenation Timeslot Allocator

This block keeps the occupancy map of a 16-slot line, where each slot carries one VC-4 (STS-3c) payload of an STM-16 (OC-48) signal. A client asks for a concatenated signal of X slots and picks one of two placement policies. The block answers one cycle later with a status and the bitmap of the slots it reserved. A separate release port returns slots to the free pool.

In standard mode a signal of size X must fill one whole aligned group of X slots. The group starts at a slot index that is a multiple of X. Only the group sizes 1, 4 and 16 fit this map. If free capacity exists but no aligned group is completely free, the request is refused, and the existing signals are never moved to make room. In arbitrary mode any X free slots will do, adjacent or not.

Top module: `slot_alloc`

## Requirements
- R1: After reset the occupancy map `occ_o` is all zero, `rsp_valid_o` and `rel_err_o` are 0, and `req_ready_o` is 1.
- R2: A request is accepted on a clock edge where `req_valid_i` and `req_ready_o` are both 1. `req_ready_o` is 0 whenever `rel_valid_i` is 1. `rsp_valid_o` is 1 for exactly the one cycle after each accepted request and is 0 otherwise.
- R3: `rsp_status_o` is 2'b01 for a grant, 2'b10 for no room and 2'b11 for a bad size. On anything other than a grant, `rsp_map_o` is zero and `occ_o` does not change.
- R4: A size of 0 is a bad size in either mode. A standard request with a size other than 1, 4 or 16 is a bad size. An arbitrary request with a size above 16 is a bad size.
- R5: A standard grant of size X covers slots k*X to k*X+X-1, where bit i of every bitmap is slot i. The block picks the smallest k whose group is entirely free.
- R6: A standard request gets no room when no aligned group is entirely free, even if at least X slots are free in total.
- R7: An arbitrary grant of size X covers the X lowest-indexed free slots. If fewer than X slots are free, the request gets no room.
- R8: The bits of a grant are set in `occ_o` on the same edge at which the response appears.
- R9: A release clears the bits of `rel_map_i` from `occ_o` on the next edge. `rel_err_o` is 1 for the cycle after a release in which any of the given bits was already free, and is 0 otherwise.
- R10: `req_mode_i` equal to 0 selects standard placement. A value of 1 selects arbitrary placement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Request can be taken this cycle |
| req_size_i | input | 5 | Requested number of slots |
| req_mode_i | input | 1 | 0 = standard, 1 = arbitrary |
| rsp_valid_o | output | 1 | Response present |
| rsp_status_o | output | 2 | Grant, no room or bad size |
| rsp_map_o | output | 16 | Slots granted |
| rel_valid_i | input | 1 | Release offered |
| rel_map_i | input | 16 | Slots to free |
| rel_err_o | output | 1 | Release named a slot that was already free |
| occ_o | output | 16 | Current occupancy map |

## Verification
The assertions assume that every input is a known value after reset. They also assume that a client may hold `req_valid_i` high while a release is in progress; the block then simply defers the request. The assertions place no limits on request sizes or release maps, so the stimulus sends sizes from 0 to 18 in both modes. Release maps are mostly subsets of the current occupancy, with free bits added now and then to produce release errors. Requests and releases are driven one at a time, each as a separate transaction.

// File: rtl/slot_alloc_pkg.sv
package slot_alloc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'b00,
    ST_GRANT   = 2'b01,
    ST_NOROOM  = 2'b10,
    ST_BADSIZE = 2'b11
  } status_e;

  localparam logic MODE_STD = 1'b0;
  localparam logic MODE_ARB = 1'b1;

  // number of power-of-four group sizes that fit in n slots
  function automatic int num_levels(int n);
    int l = 0;
    int g = 1;
    while (g <= n) begin
      l++;
      g = g * 4;
    end
    return l;
  endfunction
endpackage

// File: rtl/std_finder.sv
module std_finder #(
  parameter int NUM_SLOTS = 16,
  parameter int GROUP     = 4
) (
  input  logic [NUM_SLOTS-1:0] free_i,
  output logic                 found_o,
  output logic [NUM_SLOTS-1:0] map_o
);
  localparam int NUM_GROUPS = NUM_SLOTS / GROUP;

  // scan high to low so the lowest free group wins
  always_comb begin
    found_o = 1'b0;
    map_o   = '0;
    for (int g = NUM_GROUPS - 1; g >= 0; g--) begin
      if (&free_i[g*GROUP +: GROUP]) begin
        found_o = 1'b1;
        map_o   = '0;
        map_o[g*GROUP +: GROUP] = '1;
      end
    end
  end
endmodule

// File: rtl/arb_picker.sv
module arb_picker #(
  parameter int NUM_SLOTS = 16,
  parameter int SIZE_W    = 5
) (
  input  logic [NUM_SLOTS-1:0] free_i,
  input  logic [SIZE_W-1:0]    size_i,
  output logic                 ok_o,
  output logic [NUM_SLOTS-1:0] map_o
);
  logic [SIZE_W-1:0] cnt;

  always_comb begin
    cnt   = '0;
    map_o = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (free_i[i] && (cnt < size_i)) begin
        map_o[i] = 1'b1;
        cnt      = cnt + SIZE_W'(1);
      end
    end
    ok_o = (cnt == size_i);
  end
endmodule

// File: rtl/slot_alloc.sv
module slot_alloc
  import slot_alloc_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int SIZE_W    = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  output logic                 req_ready_o,
  input  logic [SIZE_W-1:0]    req_size_i,
  input  logic                 req_mode_i,
  output logic                 rsp_valid_o,
  output logic [1:0]           rsp_status_o,
  output logic [NUM_SLOTS-1:0] rsp_map_o,
  input  logic                 rel_valid_i,
  input  logic [NUM_SLOTS-1:0] rel_map_i,
  output logic                 rel_err_o,
  output logic [NUM_SLOTS-1:0] occ_o
);
  localparam int LEVELS = num_levels(NUM_SLOTS);

  logic [NUM_SLOTS-1:0] occ_q, free_w;
  logic [LEVELS-1:0]    lvl_found;
  logic [NUM_SLOTS-1:0] lvl_map [LEVELS];
  logic                 arb_ok;
  logic [NUM_SLOTS-1:0] arb_map;
  status_e              dec_status, status_q;
  logic [NUM_SLOTS-1:0] dec_map, map_q;
  logic                 accept, valid_q, rel_err_q;

  assign free_w      = ~occ_q;
  assign req_ready_o = ~rel_valid_i;
  assign accept      = req_valid_i & req_ready_o;

  for (genvar k = 0; k < LEVELS; k++) begin : g_lvl
    std_finder #(
      .NUM_SLOTS(NUM_SLOTS),
      .GROUP    (4**k)
    ) u_find (
      .free_i (free_w),
      .found_o(lvl_found[k]),
      .map_o  (lvl_map[k])
    );
  end

  arb_picker #(
    .NUM_SLOTS(NUM_SLOTS),
    .SIZE_W   (SIZE_W)
  ) u_arb (
    .free_i(free_w),
    .size_i(req_size_i),
    .ok_o  (arb_ok),
    .map_o (arb_map)
  );

  always_comb begin
    dec_status = ST_BADSIZE;
    dec_map    = '0;
    if (req_mode_i == MODE_ARB) begin
      if (req_size_i != '0 && int'(req_size_i) <= NUM_SLOTS) begin
        if (arb_ok) begin
          dec_status = ST_GRANT;
          dec_map    = arb_map;
        end else begin
          dec_status = ST_NOROOM;
        end
      end
    end else begin
      for (int k = 0; k < LEVELS; k++) begin
        if (int'(req_size_i) == 4**k) begin
          if (lvl_found[k]) begin
            dec_status = ST_GRANT;
            dec_map    = lvl_map[k];
          end else begin
            dec_status = ST_NOROOM;
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      occ_q     <= '0;
      valid_q   <= 1'b0;
      status_q  <= ST_IDLE;
      map_q     <= '0;
      rel_err_q <= 1'b0;
    end else begin
      valid_q   <= accept;
      status_q  <= accept ? dec_status : ST_IDLE;
      map_q     <= accept ? dec_map : '0;
      rel_err_q <= rel_valid_i && |(rel_map_i & ~occ_q);
      if (rel_valid_i) begin
        occ_q <= occ_q & ~rel_map_i;
      end else if (accept && dec_status == ST_GRANT) begin
        occ_q <= occ_q | dec_map;
      end
    end
  end

  assign rsp_valid_o  = valid_q;
  assign rsp_status_o = status_q;
  assign rsp_map_o    = map_q;
  assign rel_err_o    = rel_err_q;
  assign occ_o        = occ_q;
endmodule

// File: rtl/slot_alloc_checker.sv
module slot_alloc_checker
  import slot_alloc_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int SIZE_W    = 5
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_valid_i,
  input logic                 req_ready_o,
  input logic [SIZE_W-1:0]    req_size_i,
  input logic                 req_mode_i,
  input logic                 rsp_valid_o,
  input logic [1:0]           rsp_status_o,
  input logic [NUM_SLOTS-1:0] rsp_map_o,
  input logic                 rel_valid_i,
  input logic [NUM_SLOTS-1:0] rel_map_i,
  input logic                 rel_err_o,
  input logic [NUM_SLOTS-1:0] occ_o
);
  AST_READY_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_valid_i |-> !req_ready_o); // R2
  AST_RSP_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> rsp_valid_o); // R2
  AST_RSP_ONLY_ON_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && req_ready_o) |=> !rsp_valid_o); // R2
  AST_REFUSE_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_status_o != ST_GRANT) |-> rsp_map_o == '0); // R3
  AST_REFUSE_KEEPS_MAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (rsp_status_o == ST_GRANT || occ_o == $past(occ_o))); // R3
  AST_GRANT_WAS_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (rsp_map_o & $past(occ_o)) == '0); // R8
  AST_GRANT_SIZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=>
      (rsp_status_o != ST_GRANT || $countones(rsp_map_o) == int'($past(req_size_i)))); // R5
  AST_GRANT_MARKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_status_o == ST_GRANT) |-> (occ_o & rsp_map_o) == rsp_map_o); // R8
  AST_RELEASE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_valid_i |=> (occ_o & $past(rel_map_i)) == '0); // R9
  AST_REL_ERR_ONLY_ON_REL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rel_valid_i |=> !rel_err_o); // R9
endmodule

bind slot_alloc slot_alloc_checker #(
  .NUM_SLOTS(NUM_SLOTS),
  .SIZE_W   (SIZE_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_size_i  (req_size_i),
  .req_mode_i  (req_mode_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_status_o(rsp_status_o),
  .rsp_map_o   (rsp_map_o),
  .rel_valid_i (rel_valid_i),
  .rel_map_i   (rel_map_i),
  .rel_err_o   (rel_err_o),
  .occ_o       (occ_o)
);

// File: tb/tb_slot_alloc.sv
`timescale 1ns/1ps
module tb_slot_alloc;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [4:0]  req_size_i = '0;
  logic        req_mode_i = 1'b0;
  logic        rsp_valid_o;
  logic [1:0]  rsp_status_o;
  logic [15:0] rsp_map_o;
  logic        rel_valid_i = 1'b0;
  logic [15:0] rel_map_i = '0;
  logic        rel_err_o;
  logic [15:0] occ_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [15:0] m_occ = '0;
  logic done = 1'b0;

  always #10 clk_i = ~clk_i;

  slot_alloc dut (.*);

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // returns {status, map}
  function automatic logic [17:0] model(input logic [15:0] occ, input int size, input logic mode);
    logic [15:0] mp = '0;
    int got = 0;
    if (size == 0) return {2'b11, 16'h0};
    if (mode) begin
      if (size > 16) return {2'b11, 16'h0};
      for (int i = 0; i < 16; i++)
        if (!occ[i] && got < size) begin mp[i] = 1'b1; got++; end
      if (got < size) return {2'b10, 16'h0};
      return {2'b01, mp};
    end
    if (size != 1 && size != 4 && size != 16) return {2'b11, 16'h0};
    for (int b = 0; b < 16; b += size) begin
      mp = 16'((32'h1 << size) - 1) << b;
      if (size == 16) mp = 16'hFFFF;
      if ((occ & mp) == 0) return {2'b01, mp};
    end
    return {2'b10, 16'h0};
  endfunction

  task automatic do_req(input int size, input logic mode);
    logic [17:0] e;
    e = model(m_occ, size, mode);
    @(negedge clk_i);
    req_valid_i = 1'b1;
    req_size_i  = 5'(size);
    req_mode_i  = mode;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk(rsp_valid_o == 1'b1, "R2 rsp_valid", 32'(rsp_valid_o), 1);
    chk(rsp_status_o == e[17:16], mode ? "R7/R4 status" : "R5/R6/R4 status",
        32'(rsp_status_o), 32'(e[17:16]));
    chk(rsp_map_o == e[15:0], mode ? "R7 map" : "R5 map", 32'(rsp_map_o), 32'(e[15:0]));
    if (e[17:16] == 2'b01) m_occ = m_occ | e[15:0];
    chk(occ_o == m_occ, "R8/R3 occ", 32'(occ_o), 32'(m_occ));
    @(negedge clk_i);
    chk(rsp_valid_o == 1'b0, "R2 single pulse", 32'(rsp_valid_o), 0);
  endtask

  task automatic do_rel(input logic [15:0] mp);
    logic exp_err;
    exp_err = |(mp & ~m_occ);
    @(negedge clk_i);
    rel_valid_i = 1'b1;
    rel_map_i   = mp;
    #1;
    chk(req_ready_o == 1'b0, "R2 ready low on release", 32'(req_ready_o), 0);
    @(negedge clk_i);
    rel_valid_i = 1'b0;
    m_occ = m_occ & ~mp;
    chk(occ_o == m_occ, "R9 occ after release", 32'(occ_o), 32'(m_occ));
    chk(rel_err_o == exp_err, "R9 rel_err", 32'(rel_err_o), 32'(exp_err));
    @(negedge clk_i);
    chk(rel_err_o == 1'b0, "R9 rel_err pulse", 32'(rel_err_o), 0);
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    #25;
    chk(occ_o == 16'h0, "R1 occ", 32'(occ_o), 0);
    chk(rsp_valid_o == 1'b0, "R1 rsp_valid", 32'(rsp_valid_o), 0);
    chk(rel_err_o == 1'b0, "R1 rel_err", 32'(rel_err_o), 0);
    chk(req_ready_o == 1'b1, "R1 ready", 32'(req_ready_o), 1);
    rst_ni = 1'b1;

    // R10 R5: standard placement on an empty map
    do_req(4, 1'b0);   // 000F
    do_req(1, 1'b0);   // 0010
    do_req(4, 1'b0);   // 0F00
    do_req(16, 1'b0);  // no room
    // R4: bad sizes leave the map alone
    do_req(2, 1'b0);
    do_req(0, 1'b1);
    do_req(0, 1'b0);
    do_req(17, 1'b1);
    do_rel(16'h0F1F);
    do_req(16, 1'b0);  // FFFF
    do_rel(16'hFFFF);
    do_rel(16'h0001);  // R9 error
    // R6: fragmented free slots
    do_req(16, 1'b1);
    do_rel(16'h1842);
    do_req(4, 1'b0);   // no room despite four free
    do_req(4, 1'b1);   // R7 scattered grant
    do_req(1, 1'b1);   // R7 no room when full
    do_rel(16'hFFFF);

    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(0, 2) == 0) begin
        logic [15:0] mp;
        mp = 16'($urandom()) & m_occ;
        if ($urandom_range(0, 5) == 0) mp = mp | 16'($urandom());
        do_rel(mp);
      end else begin
        do_req(int'($urandom_range(0, 18)), 1'($urandom_range(0, 1)));
      end
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule